// File: doc/BRIEF.md
# ATA Taskfile Shadow Register File

This block holds the byte-wide taskfile registers that a storage device presents to its host. The host reaches them through a plain single-cycle register bus. It has a write strobe, a read strobe and a 3-bit address. Read data is registered and appears one cycle after the read strobe. The bus has no back-pressure: every access is accepted in the cycle it is presented, so no valid/ready pair is needed on either side.

Each of the five addressable registers keeps two bytes: the most recent one and the one it displaced. This lets a host load 48-bit addresses by writing the high-order byte first and the low-order byte second. A select bit in the control register makes reads return the older byte.

A command write models the device handshake. The busy flag is held for a fixed number of cycles. Completion is then reported through status flags, an optional error code and an interrupt line. Reading status acknowledges the interrupt, and a control bit can mask it.

Top module: `tf_shadow_regs`

## Requirements
- R1: After reset every stored byte is 0x00, the control bits are clear, `irq` is low and status reads as 0x40.
- R2: The address map is 0 feature/error, 1 sector count, 2 LBA low, 3 LBA mid, 4 LBA high, 5 device, 6 command/status, 7 control/alternate status. A write to addresses 0 to 4 moves the register's current byte into its high-order copy and stores the new byte. With the select bit clear, a read returns the newest byte.
- R3: While control bit 7 is set, reads of addresses 0 to 4 return the high-order copy. A write to any of addresses 0 to 5 clears control bit 7.
- R4: A read of address 6 clears a pending interrupt. A read of address 7 returns the same status byte and leaves the interrupt pending. A completion in the same cycle as a status read wins, so the interrupt stays pending.
- R5: While control bit 1 is set, `irq` is low. Clearing the bit shows an interrupt that is still pending.
- R6: A command write made while busy is clear sets status bit 7 (BSY) for exactly BUSY_CYCLES cycles, starting the cycle after the write. It also clears any pending interrupt. A command write made while BSY is set is ignored.
- R7: At completion BSY clears and the interrupt becomes pending. Status bit 0 (ERR) takes `done_err` and bit 3 (DRQ) takes `done_drq`. When `done_err` is high, `done_code` is pushed into the address-0 register exactly like a host write, displacing the older byte into its high-order copy.
- R8: A `drq_clr` pulse clears DRQ. The device is idle when both BSY and DRQ read as 0. Status bit 6 (DRDY) always reads 1, and the other status bits read 0.
- R9: `rdata` holds the addressed value one cycle after `rd_en`. The device register at address 5 reads back its last written byte whatever the select bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| done_err | input | 1 | Command outcome is an error (sampled at completion) |
| done_code | input | 8 | Error code loaded at completion with error |
| done_drq | input | 1 | Command wants a data phase (sampled at completion) |
| drq_clr | input | 1 | Data phase finished; clears DRQ |
| irq | output | 1 | Device interrupt |

## Verification
A read issued at one falling edge is captured at the next rising edge. The bench therefore takes `rdata` at the following falling edge, one cycle after the strobe. Changes to `irq` from a status read, a control write or a completion are due in the cycle that follows the capturing edge, and the bench samples `irq` at the falling edge after that edge. The length of BSY is measured with back-to-back alternate-status reads. The read captured at the k-th edge after the command write shows BSY for k = 1 to BUSY_CYCLES, so the bench counts exactly BUSY_CYCLES busy reads and then one final status byte.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 3;
  localparam int NUM_HIST = 5;

  localparam logic [ADDR_W-1:0] A_FEAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_DEV  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd7;

  localparam int CTL_HISEL  = 7;
  localparam int CTL_IRQOFF = 1;

  typedef struct packed {
    logic bsy;
    logic drq;
    logic err;
  } tf_flags_t;

  function automatic logic [DATA_W-1:0] pack_status(tf_flags_t f);
    return {f.bsy, 1'b1, 2'b00, f.drq, 2'b00, f.err};
  endfunction
endpackage

// File: rtl/tf_hist_reg.sv
module tf_hist_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= '0;
      prev <= '0;
    end else if (ld) begin
      prev <= cur;
      cur  <= d;
    end
  end
endmodule

// File: rtl/tf_cmd_seq.sv
module tf_cmd_seq #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (BUSY_CYCLES < 2) ? 1 : $clog2(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= LAST;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tf_shadow_regs.sv
module tf_shadow_regs
  import tf_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              done_err,
  input  logic [DATA_W-1:0] done_code,
  input  logic              done_drq,
  input  logic              drq_clr,
  output logic              irq
);
  logic [DATA_W-1:0] cur  [NUM_HIST];
  logic [DATA_W-1:0] prev [NUM_HIST];
  logic [DATA_W-1:0] dev_q, rd_mux, status;
  logic              hisel_q, irqoff_q, irq_pend_q;
  logic              busy, seq_done, cmd_go, err_load, stat_rd;
  tf_flags_t         flags_q;

  assign cmd_go   = wr_en && (addr == A_CMD) && !busy;
  assign err_load = seq_done && done_err;
  assign stat_rd  = rd_en && (addr == A_CMD);

  tf_cmd_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(cmd_go), .busy(busy), .done(seq_done)
  );

  for (genvar g = 0; g < NUM_HIST; g++) begin : g_cell
    logic              ld;
    logic [DATA_W-1:0] d;
    if (g == 0) begin : g_shared
      assign ld = (wr_en && (addr == ADDR_W'(g))) || err_load;
      assign d  = err_load ? done_code : wdata;
    end else begin : g_plain
      assign ld = wr_en && (addr == ADDR_W'(g));
      assign d  = wdata;
    end
    tf_hist_reg #(.W(DATA_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .ld(ld), .d(d), .cur(cur[g]), .prev(prev[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_q    <= '0;
      hisel_q  <= 1'b0;
      irqoff_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_CTL) begin
        hisel_q  <= wdata[CTL_HISEL];
        irqoff_q <= wdata[CTL_IRQOFF];
      end else if (addr <= A_DEV) begin
        hisel_q <= 1'b0;
        if (addr == A_DEV) dev_q <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q    <= '0;
      irq_pend_q <= 1'b0;
    end else begin
      flags_q.bsy <= busy && !seq_done || cmd_go;
      if (seq_done) begin
        flags_q.err <= done_err;
        flags_q.drq <= done_drq;
        irq_pend_q  <= 1'b1;
      end else begin
        if (cmd_go) begin
          flags_q.err <= 1'b0;
          flags_q.drq <= 1'b0;
        end else if (drq_clr) begin
          flags_q.drq <= 1'b0;
        end
        if (cmd_go || stat_rd) irq_pend_q <= 1'b0;
      end
    end
  end

  assign status = pack_status(flags_q);
  assign irq    = irq_pend_q && !irqoff_q;

  always_comb begin
    rd_mux = status;
    for (int i = 0; i < NUM_HIST; i++) begin
      if (addr == ADDR_W'(i)) rd_mux = hisel_q ? prev[i] : cur[i];
    end
    if (addr == A_DEV) rd_mux = dev_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/tf_shadow_regs_chk.sv
module tf_shadow_regs_chk
  import tf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic              busy,
  input logic              seq_done,
  input logic              irq_pend_q,
  input logic              hisel_q
);
  AST_HISEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr <= A_DEV) |=> !hisel_q); // R3

  AST_STAT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CMD && !seq_done) |=> !irq_pend_q); // R4

  AST_ALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTL && irq_pend_q && !(wr_en && addr == A_CMD)) |=> irq_pend_q); // R4

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTL && wdata[CTL_IRQOFF]) |=> !irq); // R5

  AST_CMD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMD && !busy) |=> busy); // R6

  AST_BSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq); // R6

  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> (irq_pend_q && !busy)); // R7
endmodule

bind tf_shadow_regs tf_shadow_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .irq(irq), .busy(busy), .seq_done(seq_done),
  .irq_pend_q(irq_pend_q), .hisel_q(hisel_q)
);

// File: tb/test_tf_shadow_regs.sv
`timescale 1ns/1ps
module test_tf_shadow_regs;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       done_err = 1'b0, done_drq = 1'b0, drq_clr = 1'b0;
  logic [7:0] done_code = '0;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  tf_shadow_regs #(.BUSY_CYCLES(N)) i_tf_shadow_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done_err(done_err), .done_code(done_code),
    .done_drq(done_drq), .drq_clr(drq_clr), .irq(irq)
  );

  function automatic logic [7:0] st(bit bsy, bit drq, bit err);
    return {bsy, 1'b1, 2'b00, drq, 2'b00, err};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  // Issue a command, optionally repeat it one cycle later, then poll
  // alternate status until BSY drops; return busy-cycle count and final status.
  task automatic run_cmd(bit twice, output int busy_n, output logic [7:0] fin);
    logic [7:0] v;
    wr(3'd6, 8'hC8);
    busy_n = 0;
    if (twice) begin
      wr(3'd6, 8'hC8);
      busy_n = 1;
    end
    for (int k = 0; k < 50; k++) begin
      rd(3'd7, v);
      if (!v[7]) break;
      busy_n++;
    end
    fin = v;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1", v, (a >= 6) ? 8'h40 : 8'h00);
    end
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_history();
    logic [7:0] v;
    wr(3'd1, 8'hAA);
    wr(3'd1, 8'h55);
    rd(3'd1, v);       check("R2 newest", v, 8'h55);
    wr(3'd2, 8'h11);
    wr(3'd2, 8'h22);
    wr(3'd4, 8'h9C);
    wr(3'd5, 8'hE0);
    wr(3'd7, 8'h80);
    rd(3'd1, v);       check("R3 high copy", v, 8'hAA);
    rd(3'd2, v);       check("R3 high copy", v, 8'h11);
    rd(3'd4, v);       check("R3 high copy empty", v, 8'h00);
    rd(3'd5, v);       check("R9 device", v, 8'hE0);
    wr(3'd3, 8'h77);
    rd(3'd2, v);       check("R3 select cleared", v, 8'h22);
    rd(3'd3, v);       check("R2 newest", v, 8'h77);
  endtask

  task automatic t_cmd_ok();
    int b; logic [7:0] v;
    done_err = 1'b0; done_drq = 1'b0;
    run_cmd(1'b0, b, v);
    check("R6 busy length", 8'(b), 8'(N));
    check("R7 status", v, st(0, 0, 0));
    check("R7 irq", {7'd0, irq}, 8'h01);
    rd(3'd7, v);
    check("R4 alt keeps irq", {7'd0, irq}, 8'h01);
    rd(3'd6, v);
    check("R4 status value", v, st(0, 0, 0));
    check("R4 status clears irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_cmd_err();
    int b; logic [7:0] v;
    done_err = 1'b1; done_code = 8'h04; done_drq = 1'b1;
    run_cmd(1'b1, b, v);
    check("R6 repeat ignored", 8'(b), 8'(N));
    check("R7 err status", v, st(0, 1, 1));
    rd(3'd0, v);       check("R7 error code", v, 8'h04);
    wr(3'd7, 8'h02);
    check("R5 masked", {7'd0, irq}, 8'h00);
    wr(3'd7, 8'h00);
    check("R5 unmasked", {7'd0, irq}, 8'h01);
    drq_clr = 1'b1;
    @(negedge clk);
    drq_clr = 1'b0;
    rd(3'd7, v);       check("R8 idle", v, st(0, 0, 1));
  endtask

  task automatic t_err_history();
    int b; logic [7:0] v;
    wr(3'd0, 8'h03);
    done_err = 1'b1; done_code = 8'h10; done_drq = 1'b0;
    wr(3'd6, 8'hEC);
    check("R6 cmd clears irq", {7'd0, irq}, 8'h00);
    b = 0;
    for (int k = 0; k < 50; k++) begin
      rd(3'd7, v);
      if (!v[7]) break;
      b++;
    end
    check("R6 busy length", 8'(b), 8'(N));
    rd(3'd0, v);       check("R7 new code", v, 8'h10);
    wr(3'd7, 8'h80);
    rd(3'd0, v);       check("R7 displaced byte", v, 8'h03);
    rd(3'd5, v);       check("R9 device under select", v, 8'hE0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_history();
    t_cmd_ok();
    t_cmd_err();
    t_err_history();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule